// File: doc/BRIEF.md
# Text Cursor Blink and Row Visibility Generator

This block decides, for a character display controller in text mode, whether the hardware cursor is lit on the pixel row being produced. It keeps its own time base. The time base counts millisecond ticks and flips a visible/invisible blink phase every half blink period. The full period equals the time of sixteen phase changes at a 60 Hz frame rate, which is 533 ms, so the half period is 266 ms. The phase is built from a stored deadline: each time the running time reaches the deadline, the phase inverts and the deadline moves one half period past the current time.

For each character cell and scanline, the block compares the cell address with the cursor address. It then checks the scanline against a window of first and last cursor rows taken from two control fields, and against the cell height. A disable bit turns the cursor off whatever the phase. The cursor cell is always flagged for redraw in text mode, so that a phase change reaches the screen even when the cell's character and attribute are unchanged. A switch between graphics and text mode restarts the blink timing.

Top module: `cursor_blink`

## Requirements
- R1: Reset clears the phase to invisible and sets both the time count and the deadline to zero. The first clock edge after reset therefore makes the phase visible.
- R2: The phase inverts on the first clock edge at which the millisecond count is at or past the deadline. The new deadline is the count at that edge plus 266, so the phase holds for 266 ticks after each inversion.
- R3: A change of `graphic_mode` between two edges sets the deadline to the current count and does not invert the phase at that edge. The phase then inverts on the following edge.
- R4: When bit 5 of `cur_start_reg` is 1, `cursor_on` is 0 regardless of phase, rows or cell.
- R5: The cursor rows run from `cur_start_reg[4:0]` to `cur_end_reg[4:0]`, both ends included.
- R6: No row is lit when the first row is greater than the last row, when the first row is not below `cell_height`, or when the scanline is not below `cell_height`.
- R7: `cursor_on` is 1 only when `cell_addr` equals `cursor_addr`, the phase is visible, and `graphic_mode` is 0 (text). It is 0 during the invisible phase.
- R8: `cell_redraw` is 1 exactly when `cell_addr` equals `cursor_addr` and `graphic_mode` is 0, independent of the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per elapsed millisecond |
| graphic_mode | input | 1 | 1 = graphics mode, 0 = text mode |
| cur_start_reg | input | 6 | [4:0] first cursor row, [5] cursor disable |
| cur_end_reg | input | 5 | Last cursor row |
| cell_height | input | 6 | Scanlines per character cell |
| scanline | input | 5 | Row within the current cell |
| cell_addr | input | 14 | Address of the cell being drawn |
| cursor_addr | input | 14 | Address of the cursor cell |
| cursor_on | output | 1 | Cursor lit on this pixel row |
| cell_redraw | output | 1 | Force redraw of this cell |
| blink_phase | output | 1 | Current blink phase, 1 = visible |

## Verification
The blink timer is tested with three tick patterns.
- The first edge after reset shows that a zero deadline fires at once.
- A run of exactly 266 ticks followed by one idle edge separates "at the deadline" from "one tick before".
- A mode flip in both directions, with the ticks stopped, shows the skipped edge and then the forced inversion.

The row window is tested with a table of start/end/height/scanline settings during the visible phase. The table covers both window edges, rows just outside the window, an inverted window, a start row at the cell height, a scanline past the cell height, a single-row cursor, the disable bit and a non-matching cell. Together these show which of the conditions blanks the cursor.

// File: rtl/cursor_blink_pkg.sv
package cursor_blink_pkg;

  localparam int ROW_W = 5;

  // half of the blink period in milliseconds
  function automatic int half_blink_ms(input int frame_hz, input int toggles);
    return (1000 * 2 * toggles / frame_hz) / 2;
  endfunction

  // row window test: inclusive first..last, clipped by the cell height
  function automatic logic row_in_window(
    input logic [ROW_W-1:0] first_row,
    input logic [ROW_W-1:0] last_row,
    input logic [ROW_W:0]   height,
    input logic [ROW_W-1:0] row
  );
    logic order_ok, first_ok, row_ok, in_span;
    order_ok = (first_row <= last_row);
    first_ok = ({1'b0, first_row} < height);
    row_ok   = ({1'b0, row} < height);
    in_span  = (row >= first_row) && (row <= last_row);
    return order_ok && first_ok && row_ok && in_span;
  endfunction

endpackage

// File: rtl/cblink_timer.sv
module cblink_timer #(
  parameter int TIME_W  = 32,
  parameter int HALF_MS = 266
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic graphic_mode,
  output logic phase
);
  localparam logic [TIME_W-1:0] HALF_STEP = TIME_W'(HALF_MS);

  logic [TIME_W-1:0] now_q, deadline_q;
  logic              phase_q, mode_q;
  logic              mode_flip, blink_due;

  assign mode_flip = (graphic_mode != mode_q);
  assign blink_due = !mode_flip && (now_q >= deadline_q);
  assign phase     = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now_q      <= '0;
      deadline_q <= '0;
      phase_q    <= 1'b0;
      mode_q     <= 1'b0;
    end else begin
      mode_q <= graphic_mode;
      if (ms_tick) now_q <= now_q + 1'b1;
      if (mode_flip) begin
        deadline_q <= now_q;
      end else if (blink_due) begin
        deadline_q <= now_q + HALF_STEP;
        phase_q    <= ~phase_q;
      end
    end
  end

  // R3: the edge that sees a mode change leaves the phase alone
  a_r3_hold_on_flip: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flip |=> $stable(phase_q));
  // R2: no inversion before the deadline is reached
  a_r2_quiet_before_due: assert property (@(posedge clk) disable iff (!rst_n)
    !blink_due |=> $stable(phase_q));
  // R2: the deadline never lies more than half a period ahead
  a_r2_deadline_bound: assert property (@(posedge clk) disable iff (!rst_n)
    deadline_q <= now_q + HALF_STEP);
  // R2: the count moves only on ticks
  a_r2_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_tick |=> $stable(now_q));

endmodule

// File: rtl/cblink_shape.sv
module cblink_shape
  import cursor_blink_pkg::*;
(
  input  logic [ROW_W:0]   start_field,
  input  logic [ROW_W-1:0] end_field,
  input  logic [ROW_W:0]   height,
  input  logic [ROW_W-1:0] row,
  output logic             row_hit,
  output logic             shut_off
);
  assign shut_off = start_field[ROW_W];
  assign row_hit  = !shut_off &&
                    row_in_window(start_field[ROW_W-1:0], end_field, height, row);

  // R6: a lit row always lies inside the cell
  always_comb begin
    a_r6_row_inside_cell: assert (!row_hit || ({1'b0, row} < height));
  end

endmodule

// File: rtl/cursor_blink.sv
module cursor_blink
  import cursor_blink_pkg::*;
#(
  parameter int ADDR_W            = 14,
  parameter int TIME_W            = 32,
  parameter int FRAME_HZ          = 60,
  parameter int TOGGLES_PER_FRAME = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              graphic_mode,
  input  logic [ROW_W:0]    cur_start_reg,
  input  logic [ROW_W-1:0]  cur_end_reg,
  input  logic [ROW_W:0]    cell_height,
  input  logic [ROW_W-1:0]  scanline,
  input  logic [ADDR_W-1:0] cell_addr,
  input  logic [ADDR_W-1:0] cursor_addr,
  output logic              cursor_on,
  output logic              cell_redraw,
  output logic              blink_phase
);
  localparam int HALF_MS = half_blink_ms(FRAME_HZ, TOGGLES_PER_FRAME);

  logic phase_w, row_hit, shut_off, cell_match, text_mode;

  cblink_timer #(.TIME_W(TIME_W), .HALF_MS(HALF_MS)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .ms_tick      (ms_tick),
    .graphic_mode (graphic_mode),
    .phase        (phase_w)
  );

  cblink_shape u_shape (
    .start_field (cur_start_reg),
    .end_field   (cur_end_reg),
    .height      (cell_height),
    .row         (scanline),
    .row_hit     (row_hit),
    .shut_off    (shut_off)
  );

  assign cell_match  = (cell_addr == cursor_addr);
  assign text_mode   = !graphic_mode;
  assign cell_redraw = cell_match && text_mode;
  assign cursor_on   = cell_redraw && phase_w && row_hit;
  assign blink_phase = phase_w;

  // R4: disable bit wins over everything
  a_r4_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    shut_off |-> !cursor_on);
  // R7: a lit cursor implies the redraw flag and the visible phase
  a_r7_on_needs_redraw: assert property (@(posedge clk) disable iff (!rst_n)
    cursor_on |-> (cell_redraw && blink_phase));
  // R8: graphics mode never flags a redraw
  a_r8_no_redraw_graphics: assert property (@(posedge clk) disable iff (!rst_n)
    graphic_mode |-> !cell_redraw);

endmodule

// File: tb/cursor_blink_tb.sv
`timescale 1ns/1ps
module cursor_blink_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ms_tick = 1'b0;
  logic        graphic_mode = 1'b0;
  logic [5:0]  cur_start_reg = 6'h0D;
  logic [4:0]  cur_end_reg = 5'h0E;
  logic [5:0]  cell_height = 6'd16;
  logic [4:0]  scanline = 5'd13;
  logic [13:0] cell_addr = 14'd100;
  logic [13:0] cursor_addr = 14'd100;
  logic        cursor_on, cell_redraw, blink_phase;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cursor_blink u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .graphic_mode(graphic_mode),
    .cur_start_reg(cur_start_reg), .cur_end_reg(cur_end_reg),
    .cell_height(cell_height), .scanline(scanline),
    .cell_addr(cell_addr), .cursor_addr(cursor_addr),
    .cursor_on(cursor_on), .cell_redraw(cell_redraw), .blink_phase(blink_phase)
  );

  // {start[5:0], end[4:0], height[5:0], row[4:0], match, exp_on, exp_redraw}
  localparam int NV = 12;
  localparam logic [24:0] VEC [0:NV-1] = '{
    {6'h0D, 5'h0E, 6'd16, 5'd13, 1'b1, 1'b1, 1'b1},  // R5 first row
    {6'h0D, 5'h0E, 6'd16, 5'd14, 1'b1, 1'b1, 1'b1},  // R5 last row
    {6'h0D, 5'h0E, 6'd16, 5'd12, 1'b1, 1'b0, 1'b1},  // R5 row above
    {6'h0D, 5'h0E, 6'd16, 5'd15, 1'b1, 1'b0, 1'b1},  // R5 row below
    {6'h2D, 5'h0E, 6'd16, 5'd13, 1'b1, 1'b0, 1'b1},  // R4 disabled
    {6'h0D, 5'h0E, 6'd16, 5'd13, 1'b0, 1'b0, 1'b0},  // R8 other cell
    {6'h0E, 5'h0D, 6'd16, 5'd13, 1'b1, 1'b0, 1'b1},  // R6 inverted window
    {6'h00, 5'h1F, 6'd16, 5'd15, 1'b1, 1'b1, 1'b1},  // R6 clipped, last row in cell
    {6'h00, 5'h1F, 6'd16, 5'd16, 1'b1, 1'b0, 1'b1},  // R6 row past cell
    {6'h08, 5'h0A, 6'd8,  5'd8,  1'b1, 1'b0, 1'b1},  // R6 start at height
    {6'h05, 5'h05, 6'd8,  5'd5,  1'b1, 1'b1, 1'b1},  // R5 single row
    {6'h20, 5'h1F, 6'd16, 5'd0,  1'b1, 1'b0, 1'b1}   // R4 disabled, full window
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cycles(3);
    // R1: reset state
    chk("R1", {31'd0, blink_phase}, 32'd0);
    chk("R1", {31'd0, cursor_on}, 32'd0);
    rst_n = 1'b1;
    cycles(1);
    chk("R1", {31'd0, blink_phase}, 32'd1);   // zero deadline fires at once
    // R2: 266 ticks reach the deadline, inversion one edge later
    ms_tick = 1'b1;
    cycles(266);
    chk("R2", {31'd0, blink_phase}, 32'd1);
    ms_tick = 1'b0;
    cycles(1);
    chk("R2", {31'd0, blink_phase}, 32'd0);
    #1 chk("R7", {31'd0, cursor_on}, 32'd0);    // invisible phase
    chk("R8", {31'd0, cell_redraw}, 32'd1);
    // R3: mode switch restarts the timing (count 366, deadline 532)
    ms_tick = 1'b1;
    cycles(100);
    ms_tick = 1'b0;
    graphic_mode = 1'b1;
    #1 chk("R8", {31'd0, cell_redraw}, 32'd0);
    cycles(1);
    chk("R3", {31'd0, blink_phase}, 32'd0);
    cycles(1);
    chk("R3", {31'd0, blink_phase}, 32'd1);
    chk("R7", {31'd0, cursor_on}, 32'd0);      // graphics mode
    graphic_mode = 1'b0;
    cycles(1);
    chk("R3", {31'd0, blink_phase}, 32'd1);
    cycles(1);
    chk("R3", {31'd0, blink_phase}, 32'd0);
    // R2: deadline now 632, count 366
    ms_tick = 1'b1;
    cycles(266);
    ms_tick = 1'b0;
    chk("R2", {31'd0, blink_phase}, 32'd0);
    cycles(1);
    chk("R2", {31'd0, blink_phase}, 32'd1);
    // row window table, visible phase, no ticks
    for (int i = 0; i < NV; i++) begin
      cur_start_reg = VEC[i][24:19];
      cur_end_reg   = VEC[i][18:14];
      cell_height   = VEC[i][13:8];
      scanline      = VEC[i][7:3];
      cell_addr     = VEC[i][2] ? cursor_addr : cursor_addr + 14'd1;
      cycles(1);
      #1;
      chk("R4/R5/R6/R7 row", {31'd0, cursor_on}, {31'd0, VEC[i][1]});
      chk("R8 redraw", {31'd0, cell_redraw}, {31'd0, VEC[i][0]});
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule